// File: doc/BRIEF.md
# Two-Stage Divider PWM Generator

This block drives one pulse-width-modulated output from a cascade of two counters. A prescale counter divides the input clock and produces a tick. A period counter advances on each tick. The output is high while the period count is below a programmed high time. The prescale counter spans prescale+1 input clocks and the period counter spans divider+1 ticks, so one output period lasts (prescale+1)·(divider+1) input clocks.

Software sets the block up through two 32-bit registers, written by a plain strobe. The prescale, divider and high-time fields land in staging storage. The running generator keeps its active copy until software sets a self-clearing update bit. The copy then happens at the next period boundary, or at once if the generator is stopped, so no period is ever cut short. An enable bit starts and stops the output. Clearing it forces the output low and zeroes both counters. Setting it starts a fresh period.

Top module: `pwm2_gen`

## Requirements
- R1: After reset both registers read 0 and the output is low.
- R2: Register 0 holds the period divider in bits 15:0 and the high time in bits 31:16. Register 1 holds the prescale value in bits 15:0, the update bit at bit 30 and the enable bit at bit 31. Reads return the staged values, and other bits of register 1 read 0.
- R3: While enabled, the output period is (prescale+1)·(divider+1) input clocks.
- R4: Each period starts high. The output stays high for high·(prescale+1) input clocks when 0 < high ≤ divider.
- R5: A high time of 0 holds the output low. A high time greater than the divider holds it high.
- R6: Writing the fields without setting the update bit leaves the running waveform unchanged.
- R7: Setting the update bit while running copies the staged fields at the next period boundary. Bit 30 reads 1 until that copy and 0 from the following cycle. The old waveform continues until the boundary.
- R8: Clearing the enable bit drives the output low from the next cycle. Setting it again starts a new period, high from the next cycle.
- R9: An update requested while the generator is stopped, including in the same write that sets enable, copies at once, so bit 30 reads 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that drives both counters |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 1 | Register index for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
- **Write effects:** a register write takes effect at the rising edge that captures it. The read port is combinational, so the new contents, the enable response of the output and an immediate copy can all be seen at the falling edge that follows.
- **Deferred copy:** a copy requested mid-period lands on the edge that ends the last clock of the period. The bench starts the update write in the first clock of a period, at the edge where the output has just risen. It then expects bit 30 to read 1 for exactly (prescale+1)·(divider+1)−1 falling-edge samples.
- **Waveform measurement:** period and high time are counted in falling-edge samples between two rising transitions of the output. Each count is therefore a whole number of input clocks, compared against the formulas in R3 and R4.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int FIELD_W = 16;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 1;
  localparam int HI_LSB  = 16;
  localparam int UPD_BIT = 30;
  localparam int EN_BIT  = 31;
  localparam int PAD_W   = REG_W - 2 - FIELD_W;

  typedef logic [FIELD_W-1:0] field_t;

  typedef struct packed {
    field_t pre;
    field_t div;
    field_t hi;
  } pwm_cfg_t;

  // next value of a counter that wraps after reaching its limit
  function automatic field_t next_count(field_t cnt, field_t lim);
    return (cnt == lim) ? '0 : cnt + 1'b1;
  endfunction

  // high while the period count is below the programmed high time
  function automatic logic level_at(field_t per_cnt, field_t hi);
    return per_cnt < hi;
  endfunction
endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
  import pwm2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              copy,
  output pwm_cfg_t          stage_nxt,
  output logic              upd_req,
  output logic              run_q,
  output logic              run_nxt,
  output logic              pend_q,
  output logic [REG_W-1:0]  rd_data
);
  pwm_cfg_t stage_q;
  logic     wr_timing;
  logic     wr_ctrl;
  logic     unused_bits;

  assign wr_timing   = wr_en && (addr == ADDR_W'(0));
  assign wr_ctrl     = wr_en && (addr == ADDR_W'(1));
  assign unused_bits = ^wr_data[UPD_BIT-1:FIELD_W];

  always_comb begin
    stage_nxt = stage_q;
    if (wr_timing) begin
      stage_nxt.div = wr_data[FIELD_W-1:0];
      stage_nxt.hi  = wr_data[HI_LSB +: FIELD_W];
    end
    if (wr_ctrl) begin
      stage_nxt.pre = wr_data[FIELD_W-1:0];
    end
  end

  assign run_nxt = wr_ctrl ? wr_data[EN_BIT] : run_q;
  assign upd_req = pend_q || (wr_ctrl && wr_data[UPD_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      stage_q <= stage_nxt;
      run_q   <= run_nxt;
      pend_q  <= upd_req && !copy;
    end
  end

  always_comb begin
    if (addr == ADDR_W'(0)) begin
      rd_data = {stage_q.hi, stage_q.div};
    end else begin
      rd_data = {run_q, pend_q, {PAD_W{1'b0}}, stage_q.pre};
    end
  end

  // R7: a pending request survives until a copy is taken
  assert_upd_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !copy) |=> pend_q);
endmodule

// File: rtl/pwm2_counter.sv
module pwm2_counter
  import pwm2_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   adv,
  input  field_t lim,
  output field_t cnt,
  output logic   last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= next_count(cnt, lim);
    end
  end

  assign last = adv && (cnt == lim);

  // R3: an advancing count never runs past its active limit
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (cnt <= lim));

  // R8: a cleared counter restarts from zero
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
endmodule

// File: rtl/pwm2_gen.sv
module pwm2_gen
  import pwm2_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int SEL_W  = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);
  pwm_cfg_t stage_nxt;
  pwm_cfg_t act_q;
  logic     upd_req, run_q, run_nxt, pend_q;
  logic     copy, tick, wrap, idle_clr;
  field_t   pre_cnt, per_cnt;

  pwm2_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wr_data   (reg_wdata),
    .copy      (copy),
    .stage_nxt (stage_nxt),
    .upd_req   (upd_req),
    .run_q     (run_q),
    .run_nxt   (run_nxt),
    .pend_q    (pend_q),
    .rd_data   (reg_rdata)
  );

  assign idle_clr = !run_nxt;

  pwm2_counter u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (idle_clr),
    .adv   (run_q),
    .lim   (act_q.pre),
    .cnt   (pre_cnt),
    .last  (tick)
  );

  pwm2_counter u_period (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (idle_clr),
    .adv   (tick),
    .lim   (act_q.div),
    .cnt   (per_cnt),
    .last  (wrap)
  );

  // staged fields move to the active set at a boundary or while stopped
  assign copy = upd_req && (wrap || !run_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (copy) begin
      act_q <= stage_nxt;
    end
  end

  assign pwm_out = run_q && level_at(per_cnt, act_q.hi);

  // R6: active settings move only on a copy
  assert_act_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !copy |=> $stable(act_q));

  // R7: a running copy happens only at the period boundary
  assert_copy_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (copy && run_q) |-> wrap);

  // R7: the pending flag drops only because a copy was taken
  assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(copy));

  // R8: a newly started run begins at the start of a period
  assert_fresh_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (per_cnt == '0 && pre_cnt == '0));

  // R8: a stopped generator keeps the output low
  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!pwm_out && per_cnt == '0));
endmodule

// File: tb/tb_pwm2_gen.sv
module tb_pwm2_gen;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [0:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        pwm_out;
  int          n_checks;
  int          n_fail;
  bit          done;

  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [31:0] UPD = 32'h4000_0000;

  pwm2_gen dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a falling edge; the write is captured on the next rising edge
  task automatic wr(input logic a, input logic [31:0] d);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // sync on a rising output, then count high and low clocks of one period
  task automatic measure(output int hi, output int per);
    int guard;
    int lo;
    logic prev;
    guard = 0;
    forever begin
      prev = pwm_out;
      @(negedge clk);
      guard++;
      if (!prev && pwm_out) break;
      if (guard > 5000) break;
    end
    hi = 0;
    lo = 0;
    while (pwm_out && hi < 5000) begin
      hi++;
      @(negedge clk);
    end
    while (!pwm_out && lo < 5000) begin
      lo++;
      @(negedge clk);
    end
    per = hi + lo;
  endtask

  task automatic run_cfg(input int p, input int d, input int h);
    wr(1'b1, 32'(p));
    wr(1'b0, (32'(h) << 16) | 32'(d));
    wr(1'b1, EN | UPD | 32'(p));
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rd(1'b0, v);
    check(v == 0, "R1", "reg0 after reset", v, 0);
    rd(1'b1, v);
    check(v == 0, "R1", "reg1 after reset", v, 0);
    check(pwm_out == 1'b0, "R1", "output after reset", pwm_out, 0);
  endtask

  task automatic test_layout();
    logic [31:0] v;
    @(negedge clk);
    wr(1'b0, 32'h0003_0009);
    wr(1'b1, 32'h3FFF_0004);
    rd(1'b0, v);
    check(v == 32'h0003_0009, "R2", "reg0 readback", v, 32'h0003_0009);
    rd(1'b1, v);
    check(v == 32'h0000_0004, "R2", "reg1 readback, pad bits zero", v, 32'h4);
    check(pwm_out == 1'b0, "R2", "output stays low while disabled", pwm_out, 0);
  endtask

  task automatic test_start();
    logic [31:0] v;
    int hi, per;
    wr(1'b0, 32'h0002_0004);
    wr(1'b1, EN | UPD | 32'd1);
    check(pwm_out == 1'b1, "R8", "output high right after enable", pwm_out, 1);
    rd(1'b1, v);
    check(v[30] == 1'b0, "R9", "immediate copy while stopped", v[30], 0);
    measure(hi, per);
    check(per == 10, "R3", "period pre=1 div=4", per, 10);
    check(hi == 4, "R4", "high pre=1 hi=2", hi, 4);
  endtask

  task automatic test_combos();
    int hi, per;
    run_cfg(0, 7, 3);
    measure(hi, per);
    check(per == 8, "R3", "period pre=0 div=7", per, 8);
    check(hi == 3, "R4", "high pre=0 hi=3", hi, 3);
    run_cfg(3, 2, 1);
    measure(hi, per);
    check(per == 12, "R3", "period pre=3 div=2", per, 12);
    check(hi == 4, "R4", "high pre=3 hi=1", hi, 4);
  endtask

  task automatic test_staged();
    logic [31:0] v;
    int hi, per, cnt;
    measure(hi, per);
    wr(1'b0, 32'h0005_0009);
    measure(hi, per);
    check(per == 12, "R6", "period unchanged without update", per, 12);
    check(hi == 4, "R6", "high unchanged without update", hi, 4);
    wr(1'b1, EN | UPD | 32'd3);
    cnt = 0;
    rd(1'b1, v);
    while (v[30] && cnt < 1000) begin
      cnt++;
      @(negedge clk);
      rd(1'b1, v);
    end
    check(cnt == 11, "R7", "update pending samples", cnt, 11);
    measure(hi, per);
    check(per == 40, "R7", "period after update", per, 40);
    check(hi == 20, "R7", "high after update", hi, 20);
  endtask

  task automatic test_extremes();
    int ones;
    run_cfg(0, 3, 0);
    ones = 0;
    for (int i = 0; i < 40; i++) begin
      if (pwm_out) ones++;
      @(negedge clk);
    end
    check(ones == 0, "R5", "high time 0 stays low", ones, 0);
    run_cfg(0, 3, 9);
    ones = 0;
    for (int i = 0; i < 40; i++) begin
      if (pwm_out) ones++;
      @(negedge clk);
    end
    check(ones == 40, "R5", "high time above divider stays high", ones, 40);
  endtask

  task automatic test_reenable();
    logic [31:0] v;
    int hi, per, ones;
    run_cfg(1, 4, 2);
    measure(hi, per);
    @(negedge clk);
    wr(1'b1, 32'd1);
    ones = 0;
    for (int i = 0; i < 20; i++) begin
      if (pwm_out) ones++;
      @(negedge clk);
    end
    check(ones == 0, "R8", "output low while disabled", ones, 0);
    wr(1'b1, EN | 32'd1);
    check(pwm_out == 1'b1, "R8", "re-enable starts high", pwm_out, 1);
    rd(1'b1, v);
    check(v == (EN | 32'd1), "R2", "reg1 with enable set", v, EN | 32'd1);
    measure(hi, per);
    check(per == 10, "R8", "period after re-enable", per, 10);
    check(hi == 4, "R8", "high after re-enable", hi, 4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_checks  = 0;
    n_fail    = 0;
    done      = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = 1'b0;
    reg_wdata = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_layout();
    test_start();
    test_combos();
    test_staged();
    test_extremes();
    test_reenable();
    finish_run();
  end
endmodule